// File: doc/BRIEF.md
# Floating-Point Register Boxing and Sign-Injection Unit

This unit sits between a 128-bit floating-point register file and the logic that reads and writes it. It accepts two 128-bit register values, a format code and an operation code. It produces one 128-bit register value. Single and double precision values sit in the low bits of a register. The upper bits must all be ones for the value to count as valid. Quad precision fills the whole register.

On the read side, the unit checks each narrow operand for correct boxing. Any operand that fails the check is replaced by the canonical quiet NaN of its format. The unit then applies one of four sign operations at the selected width: copy sign, copy inverted sign, XOR of signs, or plain negation. On the write side, it re-boxes narrow results by filling the upper bits with ones.

A parameter selects between a purely combinational output and one pipeline register.

Top module: `fpbox_sgnj`

## Requirements
- R1: With format code 00 (single), the result has bits 127:32 all ones, the sign at bit 31, and bits 30:0 taken from the unboxed operand A.
- R2: A single operand counts as valid only when its bits 127:32 are all ones. Any other operand, including one whose bits 127:64 are all ones but whose bits 63:32 are not, is replaced by 0x7FC00000 before use.
- R3: With format code 01 (double), the result has bits 127:64 all ones, the sign at bit 63, and bits 62:0 taken from the unboxed operand A.
- R4: A double operand counts as valid only when bits 127:64 are all ones. Otherwise it is replaced by 0x7FF8000000000000 before use.
- R5: Format codes 11 and 10 both select quad. Quad operands are used with no boxing check. The sign is bit 127, and bits 126:0 of the result equal bits 126:0 of A.
- R6: Op code 00 sets the result sign to B's sign. Op code 01 sets it to the inverse of B's sign. Op code 10 sets it to A's sign XOR B's sign.
- R7: Op code 11 negates A at the selected width. The result sign is the inverse of the unboxed A sign, and operand B has no effect on the result.
- R8: With REG_OUT=1, the result appears one clock after the inputs and is held between edges. An active-low asynchronous reset clears it to zero. With REG_OUT=0, the output follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtSel | input | 2 | Format: 00 single, 01 double, 1x quad |
| opSel | input | 2 | Operation: 00 copy sign, 01 inverted sign, 10 XOR sign, 11 negate |
| opA | input | 128 | Operand A register value |
| opB | input | 128 | Operand B register value |
| resOut | output | 128 | Boxed result register value |

## Verification
The bench builds two copies of the unit side by side: one with REG_OUT=1 and one with REG_OUT=0. Every vector is therefore checked both in the same cycle and one edge later. This setup makes the one-cycle latency, the hold between edges, and the asynchronous clear observable. The vectors include operands that are boxed at the double level but not at the single level, badly boxed B operands, and quad values whose upper bits look like a box. These cases expose any check made at the wrong width or applied to the wrong precision.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;
  localparam int FLEN = 128;
  localparam int SGL  = 32;
  localparam int DBL  = 64;

  localparam logic [SGL-1:0]  NAN_S = 32'h7FC00000;
  localparam logic [DBL-1:0]  NAN_D = 64'h7FF8000000000000;

  typedef enum logic [1:0] {
    FMT_S   = 2'b00,
    FMT_D   = 2'b01,
    FMT_RSV = 2'b10,
    FMT_Q   = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_INV  = 2'b01,
    OP_XOR  = 2'b10,
    OP_NEG  = 2'b11
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wSingle;
    logic wDouble;
    logic wQuad;
    logic invertB;
    logic xorA;
    logic negOnly;
  } ctl_t;
endpackage

// File: rtl/fpbox_ctrl.sv
module fpbox_ctrl
  import fpbox_pkg::*;
(
  input  logic [1:0] fmtSel,
  input  logic [1:0] opSel,
  output ctl_t       ctl
);
  fmt_e fmt;
  op_e  op;

  always_comb begin
    fmt = fmt_e'(fmtSel);
    op  = op_e'(opSel);
    ctl = '0;
    unique case (fmt)
      FMT_S:          ctl.wSingle = 1'b1;
      FMT_D:          ctl.wDouble = 1'b1;
      FMT_Q, FMT_RSV: ctl.wQuad   = 1'b1;
      default:        ctl.wQuad   = 1'b1;
    endcase
    unique case (op)
      OP_COPY: ;
      OP_INV:  ctl.invertB = 1'b1;
      OP_XOR:  ctl.xorA    = 1'b1;
      OP_NEG:  ctl.negOnly = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fpbox_dp.sv
module fpbox_dp
  import fpbox_pkg::*;
(
  input  ctl_t            ctl,
  input  logic [FLEN-1:0] opA,
  input  logic [FLEN-1:0] opB,
  output logic [FLEN-1:0] dpRes
);
  localparam int PADS = FLEN - SGL;
  localparam int PADD = FLEN - DBL;

  logic            aDblOk, bDblOk, aSglOk, bSglOk;
  logic [SGL-1:0]  aS, bS;
  logic [DBL-1:0]  aD, bD;
  logic            sgnS, sgnD, sgnQ;
  logic [FLEN-1:0] resS, resD, resQ;

  // Read side: box validation and canonical-NaN substitution
  always_comb begin
    aDblOk = &opA[FLEN-1:DBL];
    bDblOk = &opB[FLEN-1:DBL];
    aSglOk = aDblOk & (&opA[DBL-1:SGL]);
    bSglOk = bDblOk & (&opB[DBL-1:SGL]);
    aS = aSglOk ? opA[SGL-1:0] : NAN_S;
    bS = bSglOk ? opB[SGL-1:0] : NAN_S;
    aD = aDblOk ? opA[DBL-1:0] : NAN_D;
    bD = bDblOk ? opB[DBL-1:0] : NAN_D;
  end

  // New sign per width
  function automatic logic newSign(input ctl_t c, input logic sa, input logic sb);
    if (c.negOnly) newSign = ~sa;
    else           newSign = sb ^ (c.xorA ? sa : c.invertB);
  endfunction

  // Write side: re-box narrow results
  always_comb begin
    sgnS = newSign(ctl, aS[SGL-1], bS[SGL-1]);
    sgnD = newSign(ctl, aD[DBL-1], bD[DBL-1]);
    sgnQ = newSign(ctl, opA[FLEN-1], opB[FLEN-1]);
    resS = {{PADS{1'b1}}, sgnS, aS[SGL-2:0]};
    resD = {{PADD{1'b1}}, sgnD, aD[DBL-2:0]};
    resQ = {sgnQ, opA[FLEN-2:0]};
    if (ctl.wSingle)      dpRes = resS;
    else if (ctl.wDouble) dpRes = resD;
    else                  dpRes = resQ;
  end
endmodule

// File: rtl/fpbox_sgnj.sv
module fpbox_sgnj
  import fpbox_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       fmtSel,
  input  logic [1:0]       opSel,
  input  logic [FLEN-1:0]  opA,
  input  logic [FLEN-1:0]  opB,
  output logic [FLEN-1:0]  resOut
);
  ctl_t            ctl;
  logic [FLEN-1:0] dpRes;

  fpbox_ctrl u_ctrl (.fmtSel(fmtSel), .opSel(opSel), .ctl(ctl));
  fpbox_dp   u_dp   (.ctl(ctl), .opA(opA), .opB(opB), .dpRes(dpRes));

  generate
    if (REG_OUT) begin : g_reg
      logic [FLEN-1:0] resQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) resQ <= '0;
        else       resQ <= dpRes;
      end
      assign resOut = resQ;
    end else begin : g_comb
      assign resOut = dpRes;
    end
  endgenerate

  // Assertions on the datapath result against the input ports
  p_box_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel == 2'b00) |-> (&dpRes[FLEN-1:SGL]));

  p_canon_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel == 2'b00 && !(&opA[FLEN-1:SGL])) |-> (dpRes[SGL-2:0] == NAN_S[SGL-2:0]));

  p_box_double_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel == 2'b01) |-> (&dpRes[FLEN-1:DBL]));

  p_canon_double_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel == 2'b01 && !(&opA[FLEN-1:DBL])) |-> (dpRes[DBL-2:0] == NAN_D[DBL-2:0]));

  p_quad_body_r5: assert property (@(posedge clk) disable iff (!rstN)
    fmtSel[1] |-> (dpRes[FLEN-2:0] == opA[FLEN-2:0]));

  p_copy_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel[1] && opSel == 2'b00) |-> (dpRes[FLEN-1] == opB[FLEN-1]));

  p_negate_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel[1] && opSel == 2'b11) |-> (dpRes[FLEN-1] != opA[FLEN-1]));
endmodule

// File: tb/fpbox_sgnj_tb.sv
module fpbox_sgnj_tb;
  import fpbox_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       fmtSel = 2'b00;
  logic [1:0]       opSel = 2'b00;
  logic [FLEN-1:0]  opA = '0;
  logic [FLEN-1:0]  opB = '0;
  logic [FLEN-1:0]  resReg, resComb;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpbox_sgnj #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .opSel(opSel),
    .opA(opA), .opB(opB), .resOut(resReg));
  fpbox_sgnj #(.REG_OUT(1'b0)) u_dutComb (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .opSel(opSel),
    .opA(opA), .opB(opB), .resOut(resComb));

  localparam logic [95:0] O96 = '1;
  localparam logic [63:0] O64 = '1;

  typedef struct packed {
    logic [1:0]   fmt;
    logic [1:0]   op;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, {O96,32'h3F800000}, {O96,32'hBF800000}, {O96,32'hBF800000}, 4'd6},
    '{2'b00, 2'b01, {O96,32'h3F800000}, {O96,32'hBF800000}, {O96,32'h3F800000}, 4'd6},
    '{2'b00, 2'b10, {O96,32'hBF800000}, {O96,32'hBF800000}, {O96,32'h3F800000}, 4'd6},
    '{2'b00, 2'b11, {O96,32'h40490FDB}, {O96,32'h00000000}, {O96,32'hC0490FDB}, 4'd1},
    '{2'b00, 2'b00, {64'h0,64'hFFFFFFFF_3F800000}, {O96,32'h80000000}, {O96,32'hFFC00000}, 4'd2},
    '{2'b00, 2'b00, {O96,32'h3F800000}, {64'h7FFFFFFFFFFFFFFF,64'hFFFFFFFF_BF800000}, {O96,32'h3F800000}, 4'd2},
    '{2'b00, 2'b11, {O64,64'h00000000_3F800000}, 128'h0, {O96,32'hFFC00000}, 4'd2},
    '{2'b01, 2'b00, {O64,64'h3FF0000000000000}, {O64,64'h8000000000000000}, {O64,64'hBFF0000000000000}, 4'd6},
    '{2'b01, 2'b01, {O64,64'hBFF0000000000000}, {O64,64'hBFF0000000000000}, {O64,64'h3FF0000000000000}, 4'd6},
    '{2'b01, 2'b10, {O64,64'hC000000000000000}, {O64,64'h4000000000000000}, {O64,64'hC000000000000000}, 4'd3},
    '{2'b01, 2'b11, {O64,64'h0}, {O64,64'h0}, {O64,64'h8000000000000000}, 4'd7},
    '{2'b01, 2'b00, {64'h0,64'h3FF0000000000000}, {O64,64'h0}, {O64,64'h7FF8000000000000}, 4'd4},
    '{2'b01, 2'b01, {O64,64'h3FF0000000000000}, {64'hFFFFFFFFFFFFFFFE,64'h8000000000000000}, {O64,64'hBFF0000000000000}, 4'd4},
    '{2'b11, 2'b00, 128'h3FFF0000_00000000_00000000_00000000, 128'h80000000_00000000_00000000_00000001, 128'hBFFF0000_00000000_00000000_00000000, 4'd5},
    '{2'b11, 2'b11, 128'h00000000_00000000_00000000_00001234, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h80000000_00000000_00000000_00001234, 4'd7},
    '{2'b11, 2'b10, 128'hC0000000_00000000_00000000_00000005, 128'hC0000000_00000000_00000000_00000000, 128'h40000000_00000000_00000000_00000005, 4'd5},
    '{2'b11, 2'b01, {O96,32'h3F800000}, 128'h0, {O96,32'h3F800000}, 4'd5},
    '{2'b10, 2'b11, 128'h00000000_00000000_00000000_00001234, 128'h0, 128'h80000000_00000000_00000000_00001234, 4'd5},
    '{2'b01, 2'b11, {O64,64'h0}, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0, {O64,64'h8000000000000000}, 4'd7}
  };

  function automatic string reqName(input int r);
    case (r)
      1: reqName = "R1";
      2: reqName = "R2";
      3: reqName = "R3";
      4: reqName = "R4";
      5: reqName = "R5";
      6: reqName = "R6";
      7: reqName = "R7";
      default: reqName = "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fmtSel = v.fmt; opSel = v.op; opA = v.a; opB = v.b;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    drive(VECS[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: register cleared during reset
    check("R8", "reset value", resReg, 128'h0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check(reqName(int'(VECS[i].req)), $sformatf("vec %0d comb", i), resComb, VECS[i].exp);
      @(posedge clk);
      #1;
      check(reqName(int'(VECS[i].req)), $sformatf("vec %0d reg", i), resReg, VECS[i].exp);
    end
    // R8: register holds between edges after inputs change
    @(negedge clk);
    drive(VECS[0]);
    #1;
    check("R8", "hold before edge", resReg, VECS[NV-1].exp);
    check("R8", "comb follows", resComb, VECS[0].exp);
    @(posedge clk);
    #1;
    check("R8", "one-cycle latency", resReg, VECS[0].exp);
    // R8: asynchronous clear mid-cycle
    #1 rstN = 1'b0;
    #0.5;
    check("R8", "async clear", resReg, 128'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R7: B has no effect on negate, swept over several B values
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fmtSel = 2'b00; opSel = 2'b11; opA = {O96, 32'h80000001};
      opB = {4{32'hA5A5A5A5 ^ 32'(k * 32'h11111111)}};
      #1;
      check("R7", $sformatf("negate ignores B %0d", k), resComb, {O96, 32'h00000001});
    end
    // R2: both operands badly boxed in XOR gives canonical NaN with clear sign
    @(negedge clk);
    fmtSel = 2'b00; opSel = 2'b10; opA = 128'h0; opB = 128'h0;
    #1;
    check("R2", "both unboxed xor", resComb, {O96, 32'h7FC00000});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule